// File: doc/BRIEF.md
# Die-to-Die Link Training Controller

This block sequences a die-to-die link from power-on to a state the protocol layer may use. A state machine walks a fixed path. It holds the PHY in reset, waits for receiver termination, starts the forwarded clock and waits for lock, then either repairs around defective lanes or skips repair. It then runs a per-lane pattern error check, raises the link, and finally hands the link to the protocol layer. The physical layer is abstract: it returns status strobes and per-lane pass/fail masks. The controller returns enables and ready flags.

The link has `NUM_LANES` logical data lanes carried on `NUM_LANES + NUM_SPARE` physical lanes. When repair runs, each logical lane is steered to a healthy physical lane. Every wait state has a programmable timeout. A timeout, or a pattern error on a lane in use, sends the controller back to reset and counts one retry. When the retry budget is used up, the controller halts with a link-fail flag. If there are more bad lanes than spares, it halts with a repair-fail flag.

Top module: `d2d_link_trainer`

## Requirements
- R1: After reset the state code is 0 (reset), `phy_rst_o` is 1, and every enable and ready output is 0. The retry count and both fail flags are 0, and the lane map is the identity (logical lane i on physical lane i).
- R2: With `link_en_i` high and no fail flag set, the controller moves from reset to detect (code 1) on the next edge, and the lane drivers are enabled from detect onward. It leaves detect only on an edge where `term_det_i` is 1.
- R3: In initialize (code 2) the forwarded clock is enabled. It waits for `clk_lock_i`, then enters lane repair (code 3), or calibration (code 4) when `repair_byp_i` is 1.
- R4: In lane repair, when `scan_vld_i` is 1 and at most `NUM_SPARE` bits of `lane_fail_i` are set, logical lane i is mapped to the i-th healthy physical lane in ascending order. That physical index is placed in `lane_map_o[i*IDX_W +: IDX_W]`, and the controller enters calibration.
- R5: If more than `NUM_SPARE` lanes fail at the scan, the controller returns to reset and sets `repair_fail_o`. Both hold, with no new training attempt and no retry counted, until `rst_ni` is asserted.
- R6: In calibration, when `calib_done_i` is 1 and `calib_err_i` flags a physical lane the map uses, the controller returns to reset and the retry count rises by one. Errors only on unused lanes are ignored, and the controller enters link-up (code 5).
- R7: From link-up on, `scram_en_o` and `raw_if_rdy_o` are 1. `fec_en_o` takes the value of `fec_cfg_i` at link-up entry and ignores later changes of `fec_cfg_i` while the link stays up.
- R8: Protocol-active (code 6) follows link-up one cycle later. `flit_if_rdy_o` is 1 only there, and the retry count is cleared on entering it.
- R9: A wait state (codes 1 to 4) whose exit condition stays absent for `tmo_cycles_i` cycles returns to reset 21 to 22 cycles after entry for a limit of 20 (limit plus one to limit plus two). The retry count rises by one.
- R10: When the retry count reaches `MAX_RETRY`, `link_fail_o` is set. The controller stays in reset until `rst_ni` is asserted.
- R11: With `repair_byp_i` set, lane repair is skipped and the lane map is the identity.
- R12: `link_en_i` low puts the controller in reset on the next edge from any state, without counting a retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_en_i | input | 1 | Request to train and hold the link |
| repair_byp_i | input | 1 | Skip lane repair, use identity map |
| fec_cfg_i | input | 1 | FEC wanted when the link comes up |
| tmo_cycles_i | input | TMO_W | Wait-state timeout in cycles |
| term_det_i | input | 1 | Receiver termination detected |
| clk_lock_i | input | 1 | Forwarded clock locked |
| scan_vld_i | input | 1 | Lane fail mask valid |
| lane_fail_i | input | PHYS | Per physical lane defect flag |
| calib_done_i | input | 1 | Pattern check finished |
| calib_err_i | input | PHYS | Per physical lane pattern error |
| phy_rst_o | output | 1 | Hold PHY in reset |
| drv_en_o | output | 1 | Lane drivers enabled |
| fwd_clk_en_o | output | 1 | Forwarded clock enabled |
| repair_scan_o | output | 1 | Lane defect scan running |
| calib_run_o | output | 1 | Pattern check running |
| scram_en_o | output | 1 | Scrambler enabled |
| fec_en_o | output | 1 | FEC enabled |
| raw_if_rdy_o | output | 1 | Raw interface ready |
| flit_if_rdy_o | output | 1 | Flit interface ready to protocol layer |
| lane_map_o | output | NUM_LANES*IDX_W | Physical index per logical lane |
| state_o | output | 3 | Current state code |
| retry_cnt_o | output | RTRY_W | Failed attempts since last success |
| repair_fail_o | output | 1 | Too many defective lanes, sticky |
| link_fail_o | output | 1 | Retry budget used up, sticky |

## Verification
The bench builds the block with 8 logical lanes and 2 spares (10 physical lanes), an 8-bit timeout at 20 cycles and a retry budget of 3. This small lane count puts repair at exactly the spare limit, failures on the highest and lowest lanes, and the one-over overflow case within easy reach of random masks. The short timeout lets three consecutive timeouts exhaust the retry budget in a few hundred cycles. Random calibration errors are confined to the lanes the expected map leaves unused, which shows that those lanes are ignored.

// File: rtl/d2d_lt_pkg.sv
package d2d_lt_pkg;
  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_DETECT = 3'd1,
    ST_INIT   = 3'd2,
    ST_REPAIR = 3'd3,
    ST_CALIB  = 3'd4,
    ST_LINKUP = 3'd5,
    ST_ACTIVE = 3'd6
  } lt_state_e;
endpackage

// File: rtl/d2d_lt_timer.sv
module d2d_lt_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (run_i && (cnt_q != '1))      cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/d2d_lt_retry.sv
module d2d_lt_retry #(
  parameter int MAX_RETRY = 3,
  parameter int RTRY_W    = $clog2(MAX_RETRY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fail_i,
  input  logic              clr_i,
  output logic [RTRY_W-1:0] cnt_o,
  output logic              exhausted_o
);
  localparam logic [RTRY_W-1:0] LIMIT = RTRY_W'(MAX_RETRY);
  logic [RTRY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (fail_i && cnt_q < LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o       = cnt_q;
  assign exhausted_o = (cnt_q == LIMIT);
endmodule

// File: rtl/d2d_lt_remap.sv
module d2d_lt_remap #(
  parameter int NUM_LANES = 64,
  parameter int NUM_SPARE = 4,
  parameter int PHYS      = NUM_LANES + NUM_SPARE,
  parameter int IDX_W     = $clog2(PHYS)
) (
  input  logic [PHYS-1:0]            fail_i,
  output logic [NUM_LANES*IDX_W-1:0] map_o,
  output logic                       over_o
);
  localparam int CNT_W = $clog2(PHYS + 1);
  logic [CNT_W-1:0] nfail;

  // pack healthy lanes downward, lowest physical index first
  always_comb begin
    int k;
    k     = 0;
    map_o = '0;
    nfail = '0;
    for (int p = 0; p < PHYS; p++) begin
      if (fail_i[p]) begin
        nfail = nfail + 1'b1;
      end else begin
        if (k < NUM_LANES) map_o[k*IDX_W +: IDX_W] = IDX_W'(p);
        k = k + 1;
      end
    end
  end

  assign over_o = (nfail > CNT_W'(NUM_SPARE));
endmodule

// File: rtl/d2d_link_trainer.sv
module d2d_link_trainer
  import d2d_lt_pkg::*;
#(
  parameter int NUM_LANES = 64,
  parameter int NUM_SPARE = 4,
  parameter int TMO_W     = 16,
  parameter int MAX_RETRY = 3,
  localparam int PHYS     = NUM_LANES + NUM_SPARE,
  localparam int IDX_W    = $clog2(PHYS),
  localparam int RTRY_W   = $clog2(MAX_RETRY + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       link_en_i,
  input  logic                       repair_byp_i,
  input  logic                       fec_cfg_i,
  input  logic [TMO_W-1:0]           tmo_cycles_i,
  input  logic                       term_det_i,
  input  logic                       clk_lock_i,
  input  logic                       scan_vld_i,
  input  logic [PHYS-1:0]            lane_fail_i,
  input  logic                       calib_done_i,
  input  logic [PHYS-1:0]            calib_err_i,
  output logic                       phy_rst_o,
  output logic                       drv_en_o,
  output logic                       fwd_clk_en_o,
  output logic                       repair_scan_o,
  output logic                       calib_run_o,
  output logic                       scram_en_o,
  output logic                       fec_en_o,
  output logic                       raw_if_rdy_o,
  output logic                       flit_if_rdy_o,
  output logic [NUM_LANES*IDX_W-1:0] lane_map_o,
  output logic [2:0]                 state_o,
  output logic [RTRY_W-1:0]          retry_cnt_o,
  output logic                       repair_fail_o,
  output logic                       link_fail_o
);
  lt_state_e state_q, state_d;
  logic fail_evt, rep_fail_set, load_rep, load_id;
  logic tmo_hit, wait_st, rep_over, exhausted, fec_q, repair_fail_q;
  logic [NUM_LANES*IDX_W-1:0] id_map, rep_map, map_q;
  logic [PHYS-1:0] used_lanes;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_id
    assign id_map[i*IDX_W +: IDX_W] = IDX_W'(i);
  end

  d2d_lt_remap #(
    .NUM_LANES(NUM_LANES),
    .NUM_SPARE(NUM_SPARE)
  ) u_remap (
    .fail_i(lane_fail_i),
    .map_o (rep_map),
    .over_o(rep_over)
  );

  assign wait_st = (state_q == ST_DETECT) || (state_q == ST_INIT) ||
                   (state_q == ST_REPAIR) || (state_q == ST_CALIB);

  d2d_lt_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_d != state_q),
    .run_i    (wait_st),
    .limit_i  (tmo_cycles_i),
    .expired_o(tmo_hit)
  );

  d2d_lt_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fail_i     (fail_evt),
    .clr_i      ((state_q == ST_LINKUP) && (state_d == ST_ACTIVE)),
    .cnt_o      (retry_cnt_o),
    .exhausted_o(exhausted)
  );

  // physical lanes carrying a logical lane under the current map
  always_comb begin
    used_lanes = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (int'(map_q[i*IDX_W +: IDX_W]) < PHYS) used_lanes[map_q[i*IDX_W +: IDX_W]] = 1'b1;
    end
  end

  always_comb begin
    state_d      = state_q;
    fail_evt     = 1'b0;
    rep_fail_set = 1'b0;
    load_rep     = 1'b0;
    load_id      = 1'b0;
    if (!link_en_i) begin
      state_d = ST_RESET;
    end else begin
      case (state_q)
        ST_RESET: if (!exhausted && !repair_fail_q) state_d = ST_DETECT;
        ST_DETECT: begin
          if (term_det_i)   state_d = ST_INIT;
          else if (tmo_hit) begin fail_evt = 1'b1; state_d = ST_RESET; end
        end
        ST_INIT: begin
          if (clk_lock_i) begin
            if (repair_byp_i) begin load_id = 1'b1; state_d = ST_CALIB; end
            else state_d = ST_REPAIR;
          end else if (tmo_hit) begin
            fail_evt = 1'b1; state_d = ST_RESET;
          end
        end
        ST_REPAIR: begin
          if (scan_vld_i) begin
            if (rep_over) begin rep_fail_set = 1'b1; state_d = ST_RESET; end
            else begin load_rep = 1'b1; state_d = ST_CALIB; end
          end else if (tmo_hit) begin
            fail_evt = 1'b1; state_d = ST_RESET;
          end
        end
        ST_CALIB: begin
          if (calib_done_i) begin
            if (|(calib_err_i & used_lanes)) begin fail_evt = 1'b1; state_d = ST_RESET; end
            else state_d = ST_LINKUP;
          end else if (tmo_hit) begin
            fail_evt = 1'b1; state_d = ST_RESET;
          end
        end
        ST_LINKUP: state_d = ST_ACTIVE;
        ST_ACTIVE: state_d = ST_ACTIVE;
        default:   state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_RESET;
      map_q         <= id_map;
      fec_q         <= 1'b0;
      repair_fail_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_rep)     map_q <= rep_map;
      else if (load_id) map_q <= id_map;
      if (rep_fail_set) repair_fail_q <= 1'b1;
      // FEC choice frozen at link-up entry
      if (state_d == ST_LINKUP && state_q != ST_LINKUP) fec_q <= fec_cfg_i;
      else if (state_d != ST_LINKUP && state_d != ST_ACTIVE) fec_q <= 1'b0;
    end
  end

  assign phy_rst_o     = (state_q == ST_RESET);
  assign drv_en_o      = (state_q != ST_RESET);
  assign fwd_clk_en_o  = (state_q >= ST_INIT);
  assign repair_scan_o = (state_q == ST_REPAIR);
  assign calib_run_o   = (state_q == ST_CALIB);
  assign scram_en_o    = (state_q == ST_LINKUP) || (state_q == ST_ACTIVE);
  assign raw_if_rdy_o  = scram_en_o;
  assign fec_en_o      = fec_q;
  assign flit_if_rdy_o = (state_q == ST_ACTIVE);
  assign lane_map_o    = map_q;
  assign state_o       = state_q;
  assign repair_fail_o = repair_fail_q;
  assign link_fail_o   = exhausted;
endmodule

// File: rtl/d2d_link_trainer_chk.sv
module d2d_link_trainer_chk #(
  parameter int MAX_RETRY = 3,
  parameter int RTRY_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              link_en_i,
  input logic              term_det_i,
  input logic              phy_rst_o,
  input logic              drv_en_o,
  input logic              scram_en_o,
  input logic              fec_en_o,
  input logic              raw_if_rdy_o,
  input logic              flit_if_rdy_o,
  input logic [2:0]        state_o,
  input logic [RTRY_W-1:0] retry_cnt_o,
  input logic              repair_fail_o,
  input logic              link_fail_o
);
  // R1
  rst_drv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rst_o |-> !drv_en_o);
  // R2
  detect_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && link_en_i && !term_det_i) |=> state_o != 3'd2);
  // R7
  fec_needs_scram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fec_en_o |-> scram_en_o);
  // R7
  fec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_if_rdy_o && $past(flit_if_rdy_o)) |-> $stable(fec_en_o));
  // R8
  flit_after_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flit_if_rdy_o) |-> ($past(raw_if_rdy_o) && $past(state_o) == 3'd5));
  // R8
  flit_needs_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flit_if_rdy_o |-> (raw_if_rdy_o && scram_en_o));
  // R9
  retry_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_cnt_o <= RTRY_W'(MAX_RETRY));
  // R10
  link_fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_fail_o |=> (link_fail_o && state_o == 3'd0));
  // R5
  repair_fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repair_fail_o |=> (repair_fail_o && state_o == 3'd0));
  // R12
  en_low_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_i |=> state_o == 3'd0);
endmodule

bind d2d_link_trainer d2d_link_trainer_chk #(
  .MAX_RETRY(MAX_RETRY),
  .RTRY_W   (RTRY_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .link_en_i    (link_en_i),
  .term_det_i   (term_det_i),
  .phy_rst_o    (phy_rst_o),
  .drv_en_o     (drv_en_o),
  .scram_en_o   (scram_en_o),
  .fec_en_o     (fec_en_o),
  .raw_if_rdy_o (raw_if_rdy_o),
  .flit_if_rdy_o(flit_if_rdy_o),
  .state_o      (state_o),
  .retry_cnt_o  (retry_cnt_o),
  .repair_fail_o(repair_fail_o),
  .link_fail_o  (link_fail_o)
);

// File: tb/d2d_link_trainer_tb_top.sv
`timescale 1ns/1ps
module d2d_link_trainer_tb_top;
  localparam int NL  = 8;
  localparam int NS  = 2;
  localparam int PH  = NL + NS;
  localparam int IW  = $clog2(PH);
  localparam int TW  = 8;
  localparam int MR  = 3;
  localparam int RW  = $clog2(MR + 1);
  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic link_en_i = 0, repair_byp_i = 0, fec_cfg_i = 0;
  logic [TW-1:0] tmo_cycles_i = TW'(TMO);
  logic term_det_i = 0, clk_lock_i = 0, scan_vld_i = 0, calib_done_i = 0;
  logic [PH-1:0] lane_fail_i = '0, calib_err_i = '0;
  logic phy_rst_o, drv_en_o, fwd_clk_en_o, repair_scan_o, calib_run_o;
  logic scram_en_o, fec_en_o, raw_if_rdy_o, flit_if_rdy_o;
  logic [NL*IW-1:0] lane_map_o;
  logic [2:0] state_o;
  logic [RW-1:0] retry_cnt_o;
  logic repair_fail_o, link_fail_o;
  int nvec = 0, nerr = 0;

  always #2.5 clk = ~clk;

  d2d_link_trainer #(.NUM_LANES(NL), .NUM_SPARE(NS), .TMO_W(TW), .MAX_RETRY(MR)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .link_en_i(link_en_i), .repair_byp_i(repair_byp_i),
    .fec_cfg_i(fec_cfg_i), .tmo_cycles_i(tmo_cycles_i), .term_det_i(term_det_i),
    .clk_lock_i(clk_lock_i), .scan_vld_i(scan_vld_i), .lane_fail_i(lane_fail_i),
    .calib_done_i(calib_done_i), .calib_err_i(calib_err_i), .phy_rst_o(phy_rst_o),
    .drv_en_o(drv_en_o), .fwd_clk_en_o(fwd_clk_en_o), .repair_scan_o(repair_scan_o),
    .calib_run_o(calib_run_o), .scram_en_o(scram_en_o), .fec_en_o(fec_en_o),
    .raw_if_rdy_o(raw_if_rdy_o), .flit_if_rdy_o(flit_if_rdy_o), .lane_map_o(lane_map_o),
    .state_o(state_o), .retry_cnt_o(retry_cnt_o), .repair_fail_o(repair_fail_o),
    .link_fail_o(link_fail_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // logical i sits on the physical lane that has exactly i healthy lanes below it
  function automatic logic [NL*IW-1:0] exp_map(input logic [PH-1:0] fm);
    logic [NL*IW-1:0] r;
    for (int i = 0; i < NL; i++) begin
      int seen;
      seen = 0;
      r[i*IW +: IW] = IW'(i);
      for (int p = 0; p < PH; p++) begin
        if (!fm[p]) begin
          if (seen == i) r[i*IW +: IW] = IW'(p);
          seen++;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [PH-1:0] used_of(input logic [NL*IW-1:0] m);
    logic [PH-1:0] u = '0;
    for (int i = 0; i < NL; i++) u[m[i*IW +: IW]] = 1'b1;
    return u;
  endfunction

  function automatic logic [PH-1:0] rand_fails(input int nbits);
    logic [PH-1:0] f = '0;
    for (int b = 0; b < nbits; b++) f[$urandom % PH] = 1'b1;
    return f;
  endfunction

  task automatic do_reset();
    link_en_i = 0; scan_vld_i = 0; calib_done_i = 0; calib_err_i = '0;
    rst_ni = 0;
    step(2);
    rst_ni = 1;
    step(1);
  endtask

  task automatic go_to_calib(input logic byp, input logic [PH-1:0] fm, input logic fec);
    link_en_i = 1; term_det_i = 1; clk_lock_i = 1; repair_byp_i = byp;
    fec_cfg_i = fec; lane_fail_i = fm; scan_vld_i = 0; calib_done_i = 0;
    step(1);
    chk("R2 detect state", state_o, 1);
    chk("R2 drivers on", drv_en_o, 1);
    step(1);
    chk("R3 init state", state_o, 2);
    chk("R3 fwd clock on", fwd_clk_en_o, 1);
    step(1);
    if (byp) begin
      chk("R11 repair skipped", state_o, 4);
      chk("R11 identity map", lane_map_o, exp_map('0));
    end else begin
      chk("R4 repair state", state_o, 3);
      chk("R4 scan running", repair_scan_o, 1);
      scan_vld_i = 1;
      step(1);
      scan_vld_i = 0;
      chk("R4 calib state", state_o, 4);
      chk("R4 remap", lane_map_o, exp_map(fm));
    end
  endtask

  task automatic finish_train(input logic fec, input logic [NL*IW-1:0] m);
    calib_err_i = PH'($urandom) & ~used_of(m);
    calib_done_i = 1;
    step(1);
    calib_done_i = 0; calib_err_i = '0;
    chk("R6 unused-lane errors ignored", state_o, 5);
    chk("R7 scrambler on", scram_en_o, 1);
    chk("R7 raw ready", raw_if_rdy_o, 1);
    chk("R7 fec follows cfg", fec_en_o, fec);
    chk("R8 flit not yet ready", flit_if_rdy_o, 0);
    fec_cfg_i = ~fec;
    step(1);
    chk("R8 active state", state_o, 6);
    chk("R8 flit ready", flit_if_rdy_o, 1);
    chk("R8 retry cleared", retry_cnt_o, 0);
    step(1);
    chk("R7 fec cfg change ignored", fec_en_o, fec);
    link_en_i = 0;
    step(1);
    chk("R12 drop to reset", state_o, 0);
    chk("R12 flit off", flit_if_rdy_o, 0);
    chk("R12 scrambler off", scram_en_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 phy reset", phy_rst_o, 1);
    chk("R1 drivers off", drv_en_o, 0);
    chk("R1 enables off", {fwd_clk_en_o, repair_scan_o, calib_run_o, scram_en_o, fec_en_o,
                           raw_if_rdy_o, flit_if_rdy_o}, 0);
    chk("R1 flags", {retry_cnt_o, repair_fail_o, link_fail_o}, 0);
    chk("R1 identity map", lane_map_o, exp_map('0));

    // R2 detect waits for termination
    link_en_i = 1; term_det_i = 0;
    step(1);
    chk("R2 detect entered", state_o, 1);
    step(5);
    chk("R2 hold without termination", state_o, 1);
    term_det_i = 1; clk_lock_i = 0;
    step(1);
    chk("R3 init entered", state_o, 2);
    step(5);
    chk("R3 hold without lock", state_o, 2);
    link_en_i = 0;
    step(1);
    chk("R12 drop from init", state_o, 0);
    chk("R12 no retry counted", retry_cnt_o, 0);

    // R4 boundary: two lowest lanes failed, then two highest
    go_to_calib(0, PH'(3), 1);
    finish_train(1, exp_map(PH'(3)));
    go_to_calib(0, {2'b11, {(PH-2){1'b0}}}, 0);
    finish_train(0, exp_map({2'b11, {(PH-2){1'b0}}}));

    // random trainings
    for (int it = 0; it < 40; it++) begin
      logic byp, fec;
      logic [PH-1:0] fm;
      byp = 1'($urandom);
      fec = 1'($urandom);
      fm  = rand_fails($urandom % (NS + 1));
      go_to_calib(byp, fm, fec);
      finish_train(fec, byp ? exp_map('0) : exp_map(fm));
    end

    // R6 error on a used lane, then R8 retry clear on success
    begin
      logic [NL*IW-1:0] m;
      m = exp_map(PH'(4));
      go_to_calib(0, PH'(4), 0);
      calib_err_i = '0;
      calib_err_i[m[5*IW +: IW]] = 1'b1;
      calib_done_i = 1;
      step(1);
      calib_done_i = 0; calib_err_i = '0;
      chk("R6 used-lane error to reset", state_o, 0);
      chk("R6 retry counted", retry_cnt_o, 1);
      link_en_i = 0;
      step(1);
      go_to_calib(0, PH'(4), 0);
      finish_train(0, m);
    end

    // R5 too many failed lanes
    do_reset();
    link_en_i = 1; term_det_i = 1; clk_lock_i = 1; repair_byp_i = 0;
    lane_fail_i = PH'(1) | PH'(16) | (PH'(1) << (PH - 1));
    step(3);
    chk("R5 in repair", state_o, 3);
    scan_vld_i = 1;
    step(1);
    scan_vld_i = 0;
    chk("R5 back to reset", state_o, 0);
    chk("R5 repair fail flag", repair_fail_o, 1);
    chk("R5 no retry counted", retry_cnt_o, 0);
    step(6);
    chk("R5 halted", state_o, 0);
    chk("R5 flag sticky", repair_fail_o, 1);
    do_reset();
    chk("R5 flag cleared by reset", repair_fail_o, 0);

    // R9 timeouts, R10 exhaustion
    link_en_i = 1; term_det_i = 0;
    for (int r = 1; r <= MR; r++) begin
      int k, w;
      w = 0;
      while (state_o != 3'd1 && w < 5) begin step(1); w++; end
      k = 0;
      while (state_o != 3'd0 && k < 60) begin step(1); k++; end
      chk("R9 timeout window", (k >= TMO + 1 && k <= TMO + 2), 1);
      chk("R9 retry count", retry_cnt_o, r);
    end
    chk("R10 link fail", link_fail_o, 1);
    term_det_i = 1;
    step(6);
    chk("R10 halted in reset", state_o, 0);
    chk("R10 link fail sticky", link_fail_o, 1);
    do_reset();
    chk("R10 cleared by reset", link_fail_o, 0);

    // R9 timeout in calibration
    go_to_calib(1, '0, 0);
    begin
      int k;
      k = 0;
      while (state_o != 3'd0 && k < 60) begin step(1); k++; end
      chk("R9 calib timeout window", (k >= TMO + 1 && k <= TMO + 2), 1);
      chk("R9 calib retry count", retry_cnt_o, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule